// File: doc/BRIEF.md
# Register-Mapped Arithmetic Unit

A small AXI4-Lite slave that holds two operands, a command word and a result. Software writes the two operands and then a command code. On the next clock edge the block computes the sum, the wrapped product or the difference of the operands and stores it in a result register. Software can read that register but cannot write it. The block has no busy state. Software waits for the write response, then reads the result.

The command register also drives a level interrupt. The interrupt is high whenever a non-zero command is stored. Software clears it by writing zero to the command register. Each operand and command write uses the byte strobes. Every response is OKAY, including the response to a write aimed at the result.

Top module: `arith_regfile_axil`

## Requirements
- R1: After an active-low reset, all four registers read zero and `irq` is low.
- R2: The word offset is taken from address bits [3:2]. Offset 0 is the command, 1 is operand A, 2 is operand B and 3 is the result. A write to offsets 0 to 2 reads back unchanged.
- R3: Command code 1 makes the result A + B, wrapped modulo 2^32.
- R4: Command code 2 makes the result the low 32 bits of A × B.
- R5: Command code 3 makes the result B − A, wrapped modulo 2^32.
- R6: Command code 0, or any code above 3, leaves the result at its previous value, even when the operands change.
- R7: A write to offset 3 is answered with BRESP = 0 (OKAY) and does not alter the result.
- R8: On a write to offsets 0 to 2, only the bytes whose write-strobe bit is 1 are updated (strobe bit i covers data bits 8i+7..8i).
- R9: `irq` is 1 exactly while the command register holds a non-zero value.
- R10: BVALID and RVALID stay high, with RDATA held, until the matching ready is seen. BRESP and RRESP are always 0.
- R11: The result updates one clock edge after the command or operand register changes. A read issued after the write response handshake of the last write returns the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| irq | output | 1 | Level interrupt, high while a command is stored |

## Verification
If the command or operand registers hold a wrong value, the error shows on the first read of offsets 0 to 2. It also shows in the result one edge later, whenever a valid code is stored. A wrong command value also changes `irq` in the same cycle, because `irq` is decoded directly from that register. If the result register is corrupted by a bus write or by an idle code, the error stays hidden until the next poll of offset 3. For that reason each such stimulus is followed by an immediate read of the result.

// File: rtl/arith_regfile_axil.sv
module arith_regfile_axil #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                aclk,
  input  logic                aresetn,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [1:0]          s_bresp,
  output logic                s_bvalid,
  input  logic                s_bready,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic                s_arvalid,
  output logic                s_arready,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rvalid,
  input  logic                s_rready,
  output logic                irq
);
  localparam int NB = DATA_W / 8;
  localparam logic [1:0] IDX_CMD = 2'd0, IDX_A = 2'd1, IDX_B = 2'd2, IDX_RES = 2'd3;
  localparam logic [DATA_W-1:0] OP_ADD = DATA_W'(1), OP_MUL = DATA_W'(2), OP_SUB = DATA_W'(3);

  logic [DATA_W-1:0] cmd_q, opa_q, opb_q, res_q, res_d;
  logic              wr_fire, rd_fire;
  logic [1:0]        wr_idx, rd_idx;

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] cur,
                                               input logic [DATA_W-1:0] nw,
                                               input logic [NB-1:0] be);
    logic [DATA_W-1:0] m;
    m = cur;
    for (int i = 0; i < NB; i++)
      if (be[i]) m[8*i +: 8] = nw[8*i +: 8];
    return m;
  endfunction

  assign wr_fire   = s_awvalid & s_wvalid & ~s_bvalid;
  assign s_awready = wr_fire;
  assign s_wready  = wr_fire;
  assign wr_idx    = s_awaddr[3:2];
  assign rd_idx    = s_araddr[3:2];
  assign s_arready = ~s_rvalid;
  assign rd_fire   = s_arvalid & s_arready;
  assign s_bresp   = 2'b00;
  assign s_rresp   = 2'b00;
  assign irq       = |cmd_q;

  always_comb begin
    case (cmd_q)
      OP_ADD:  res_d = opa_q + opb_q;
      OP_MUL:  res_d = opa_q * opb_q;
      OP_SUB:  res_d = opb_q - opa_q;
      default: res_d = res_q;
    endcase
  end

  always_ff @(posedge aclk) begin
    if (!aresetn) begin
      cmd_q <= '0; opa_q <= '0; opb_q <= '0; res_q <= '0;
      s_bvalid <= 1'b0; s_rvalid <= 1'b0; s_rdata <= '0;
    end else begin
      res_q <= res_d;
      if (wr_fire) begin
        case (wr_idx)
          IDX_CMD: cmd_q <= merge(cmd_q, s_wdata, s_wstrb);
          IDX_A:   opa_q <= merge(opa_q, s_wdata, s_wstrb);
          IDX_B:   opb_q <= merge(opb_q, s_wdata, s_wstrb);
          default: ;
        endcase
      end
      if (wr_fire) s_bvalid <= 1'b1;
      else if (s_bready) s_bvalid <= 1'b0;
      if (rd_fire) begin
        s_rvalid <= 1'b1;
        case (rd_idx)
          IDX_CMD: s_rdata <= cmd_q;
          IDX_A:   s_rdata <= opa_q;
          IDX_B:   s_rdata <= opb_q;
          default: s_rdata <= res_q;
        endcase
      end else if (s_rready) s_rvalid <= 1'b0;
    end
  end

  a_r10_bvalid_hold: assert property (@(posedge aclk) disable iff (!aresetn)
    s_bvalid && !s_bready |=> s_bvalid);
  a_r10_rdata_hold: assert property (@(posedge aclk) disable iff (!aresetn)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
  a_r6_res_only_on_cmd: assert property (@(posedge aclk) disable iff (!aresetn)
    !$stable(res_q) |-> ($past(cmd_q) >= OP_ADD && $past(cmd_q) <= OP_SUB));
  a_r7_res_not_bus: assert property (@(posedge aclk) disable iff (!aresetn)
    wr_fire && wr_idx == IDX_RES && cmd_q == '0 |=> $stable(res_q));
  a_r9_irq_from_write: assert property (@(posedge aclk) disable iff (!aresetn)
    $rose(irq) |-> $past(wr_fire && wr_idx == IDX_CMD));
endmodule

// File: tb/arith_regfile_axil_tb.sv
module arith_regfile_axil_tb;
  logic clk = 0, rstn = 0;
  always #10 clk = ~clk;

  logic [3:0] awaddr = 0, araddr = 0;
  logic awvalid = 0, wvalid = 0, arvalid = 0, bready = 1, rready = 1;
  logic [31:0] wdata = 0;
  logic [3:0] wstrb = 0;
  logic awready, wready, bvalid, arready, rvalid, irq;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;

  arith_regfile_axil u_dut (
    .aclk(clk), .aresetn(rstn),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .irq(irq));

  int total = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] idx, logic [31:0] d, logic [3:0] be = 4'hF);
    awaddr = {idx, 2'b00}; wdata = d; wstrb = be; awvalid = 1; wvalid = 1;
    while (!awready) @(negedge clk);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    check("R10 bvalid", {31'd0, bvalid}, 32'd1);
    check("R7 R10 bresp", {30'd0, bresp}, 32'd0);
    @(negedge clk);
  endtask

  task automatic rd(logic [1:0] idx, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    araddr = {idx, 2'b00}; arvalid = 1;
    while (!arready) @(negedge clk);
    @(negedge clk);
    arvalid = 0;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rvalid && rready) begin
      if (exp_q.size() == 0) check("scoreboard empty", rdata, 32'hx);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
      check("R10 rresp", {30'd0, rresp}, 32'd0);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  logic [31:0] a, b, last;
  initial begin
    repeat (3) @(negedge clk);
    rstn = 1;
    @(negedge clk);
    check("R1 irq reset", {31'd0, irq}, 0);
    rd(0, 0, "R1 cmd reset"); rd(1, 0, "R1 A reset");
    rd(2, 0, "R1 B reset"); rd(3, 0, "R1 result reset");

    wr(1, 32'h1234_5678); wr(2, 32'hCAFE_0001);
    rd(1, 32'h1234_5678, "R2 A readback"); rd(2, 32'hCAFE_0001, "R2 B readback");

    a = 32'hFFFF_FFFF; b = 32'd2;
    wr(1, a); wr(2, b); wr(0, 1);
    check("R9 irq on", {31'd0, irq}, 1);
    rd(0, 1, "R2 cmd readback");
    rd(3, a + b, "R3 R11 add wrap");

    a = 32'h0001_2345; b = 32'h0000_6789;
    wr(1, a); wr(2, b); wr(0, 2);
    rd(3, a * b, "R4 mul");
    a = 32'h0001_0000; b = 32'h0001_0003;
    wr(1, a); wr(2, b);
    rd(3, a * b, "R4 mul truncate R11");

    a = 32'd5; b = 32'd3;
    wr(1, a); wr(2, b); wr(0, 3);
    rd(3, b - a, "R5 sub wrap");
    last = b - a;

    wr(0, 0);
    check("R9 irq off", {31'd0, irq}, 0);
    wr(1, 32'd99);
    rd(3, last, "R6 code0 holds");
    wr(0, 7);
    check("R9 irq code7", {31'd0, irq}, 1);
    wr(2, 32'd1234);
    rd(3, last, "R6 code7 holds");

    wr(0, 0);
    wr(3, 32'hDEAD_BEEF);
    rd(3, last, "R7 result read-only");

    wr(1, 32'hAABB_CCDD);
    wr(1, 32'h1122_3344, 4'b0101);
    rd(1, 32'hAA22_CC44, "R8 strobe");
    wr(0, 32'h0000_0100, 4'b0010);
    check("R8 R9 irq byte1", {31'd0, irq}, 1);
    rd(0, 32'h0000_0100, "R8 cmd strobe");

    repeat (4) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule